// File: doc/BRIEF.md
# Fuse Array Power Sequencer

This block brings a one-time-programmable fuse array up before a read session and takes it down afterwards. On a power-up request it raises a write-mask override, closes a first power switch, waits a programmable settle interval, closes a second power switch and then releases core isolation so that fuse data can reach the core. A power-down request runs the same steps in reverse. Isolation is reapplied first, then the second switch opens, the block waits the settle interval again, then the first switch opens, and the override is released last.

One silicon variant also needs a burst-read flag. When the variant input is high at the moment a request is accepted, the flag is set as the last power-up step and cleared as the first power-down step. When the bypass input is high at the moment a request is accepted, the sequence completes at once and no control output moves. Each accepted sequence ends with a one-cycle done pulse and an update of the ready status. Requests that arrive during a sequence are ignored, as are requests that ask for the state the block is already in.

Top module: `fuse_pwr_seq`

## Requirements
- R1: After reset, iso_o is 1 and wmask_o, stage1_o, stage2_o, burst_o, ready_o, busy_o and done_o are all 0.
- R2: A power-up request accepted at clock edge E0 (block idle, ready_o=0, bypass_i=0) sets wmask_o at E0 and stage1_o at E0+1.
- R3: The gap between the two power stages is exactly CYC_PER_MS cycles in both directions. On power-up, stage2_o rises CYC_PER_MS edges after stage1_o rises. On power-down, stage1_o falls CYC_PER_MS edges after stage2_o falls.
- R4: On power-up, iso_o falls one edge after stage2_o rises. Without the variant, that same edge sets ready_o and pulses done_o.
- R5: A power-down request accepted at edge F0 (idle, ready_o=1, bypass_i=0) changes the outputs in this order, with b=1 if variant_i was high at F0 and b=0 otherwise. iso_o rises at F0+b. stage2_o falls at F0+b+1. stage1_o falls at F0+b+1+CYC_PER_MS. wmask_o falls at F0+b+2+CYC_PER_MS, together with ready_o clearing and done_o pulsing.
- R6: With variant_i high when a sequence is accepted, burst_o rises one edge after iso_o falls on power-up, and that edge ends the sequence. On power-down, burst_o falls at F0. The variant is held from acceptance, so changing variant_i mid-sequence has no effect.
- R7: With bypass_i high when a request is accepted, done_o pulses in the next cycle and ready_o toggles. wmask_o, stage1_o, stage2_o, iso_o and burst_o do not change.
- R8: busy_o is 1 from acceptance until the edge that ends the sequence. Requests during that time are ignored. A power-up request while ready_o=1, or a power-down request while ready_o=0, leaves every output unchanged.
- R9: done_o is high for exactly one cycle per accepted sequence, and ready_o changes only in that cycle.
- R10: At all times, stage2_o implies stage1_o, stage1_o implies wmask_o, and iso_o=0 implies stage2_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | Complete sequences without moving outputs |
| variant_i | input | 1 | Silicon variant needing the burst flag |
| up_req_i | input | 1 | Power-up request |
| down_req_i | input | 1 | Power-down request |
| wmask_o | output | 1 | Write-mask override |
| stage1_o | output | 1 | First power-switch stage |
| stage2_o | output | 1 | Second power-switch stage |
| iso_o | output | 1 | Core isolation, 1 = isolated |
| burst_o | output | 1 | Burst-read flag |
| ready_o | output | 1 | Array powered and usable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |

## Verification
Some properties are checked on every cycle: the nesting of the controls (override under stage one, stage one under stage two, isolation released only at full power), the burst flag only with isolation open, the exact settle gap in both directions, the single-cycle done pulse with a ready toggle, and quiet outputs while idle. The exact cycle at which each step lands relative to the request can only be shown by the bench's scenarios. The same holds for the reverse order with the variant offset, for variant latching, for bypass completion and for ignored requests. The bench covers these by sweeping variant, bypass and mid-sequence request noise against a waveform computed from the settle length.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UP_S1,
        ST_UP_WAIT,
        ST_UP_ISO,
        ST_UP_BURST,
        ST_DN_ISO,
        ST_DN_S2,
        ST_DN_WAIT,
        ST_DN_WMASK
    } fps_state_e;

    typedef struct packed {
        fps_state_e st;
        logic       wmask;
        logic       s1;
        logic       s2;
        logic       iso;
        logic       burst;
        logic       ready;
        logic       done;
        logic       varnt;
    } fps_ctrl_t;

endpackage

// File: rtl/fps_settle_timer.sv
module fps_settle_timer #(
    parameter int CYC_PER_MS = 200000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS + 1) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYC_PER_MS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bypass_i,
    input  logic variant_i,
    input  logic up_req_i,
    input  logic down_req_i,
    input  logic expired_i,
    output logic load_o,
    output logic wmask_o,
    output logic stage1_o,
    output logic stage2_o,
    output logic iso_o,
    output logic burst_o,
    output logic ready_o,
    output logic busy_o,
    output logic done_o
);
    fps_ctrl_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        load_o   = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (up_req_i && !s_q.ready) begin
                    if (bypass_i) begin
                        s_d.ready = 1'b1;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.varnt = variant_i;
                        s_d.wmask = 1'b1;
                        s_d.st    = ST_UP_S1;
                    end
                end else if (down_req_i && s_q.ready) begin
                    if (bypass_i) begin
                        s_d.ready = 1'b0;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.varnt = variant_i;
                        if (variant_i) begin
                            s_d.burst = 1'b0;
                            s_d.st    = ST_DN_ISO;
                        end else begin
                            s_d.iso = 1'b1;
                            s_d.st  = ST_DN_S2;
                        end
                    end
                end
            end
            ST_UP_S1: begin
                s_d.s1 = 1'b1;
                load_o = 1'b1;
                s_d.st = ST_UP_WAIT;
            end
            ST_UP_WAIT: begin
                if (expired_i) begin
                    s_d.s2 = 1'b1;
                    s_d.st = ST_UP_ISO;
                end
            end
            ST_UP_ISO: begin
                s_d.iso = 1'b0;
                if (s_q.varnt) begin
                    s_d.st = ST_UP_BURST;
                end else begin
                    s_d.ready = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.st    = ST_IDLE;
                end
            end
            ST_UP_BURST: begin
                s_d.burst = 1'b1;
                s_d.ready = 1'b1;
                s_d.done  = 1'b1;
                s_d.st    = ST_IDLE;
            end
            ST_DN_ISO: begin
                s_d.iso = 1'b1;
                s_d.st  = ST_DN_S2;
            end
            ST_DN_S2: begin
                s_d.s2 = 1'b0;
                load_o = 1'b1;
                s_d.st = ST_DN_WAIT;
            end
            ST_DN_WAIT: begin
                if (expired_i) begin
                    s_d.s1 = 1'b0;
                    s_d.st = ST_DN_WMASK;
                end
            end
            ST_DN_WMASK: begin
                s_d.wmask = 1'b0;
                s_d.ready = 1'b0;
                s_d.done  = 1'b1;
                s_d.st    = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.st    <= ST_IDLE;
            s_q.wmask <= 1'b0;
            s_q.s1    <= 1'b0;
            s_q.s2    <= 1'b0;
            s_q.iso   <= 1'b1;
            s_q.burst <= 1'b0;
            s_q.ready <= 1'b0;
            s_q.done  <= 1'b0;
            s_q.varnt <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wmask_o  = s_q.wmask;
    assign stage1_o = s_q.s1;
    assign stage2_o = s_q.s2;
    assign iso_o    = s_q.iso;
    assign burst_o  = s_q.burst;
    assign ready_o  = s_q.ready;
    assign done_o   = s_q.done;
    assign busy_o   = (s_q.st != ST_IDLE);

endmodule

// File: rtl/fuse_pwr_seq.sv
module fuse_pwr_seq #(
    parameter int CYC_PER_MS = 200000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bypass_i,
    input  logic variant_i,
    input  logic up_req_i,
    input  logic down_req_i,
    output logic wmask_o,
    output logic stage1_o,
    output logic stage2_o,
    output logic iso_o,
    output logic burst_o,
    output logic ready_o,
    output logic busy_o,
    output logic done_o
);
    logic load;
    logic expired;

    fps_settle_timer #(
        .CYC_PER_MS(CYC_PER_MS)
    ) i_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load),
        .expired_o (expired)
    );

    fps_ctrl i_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bypass_i   (bypass_i),
        .variant_i  (variant_i),
        .up_req_i   (up_req_i),
        .down_req_i (down_req_i),
        .expired_i  (expired),
        .load_o     (load),
        .wmask_o    (wmask_o),
        .stage1_o   (stage1_o),
        .stage2_o   (stage2_o),
        .iso_o      (iso_o),
        .burst_o    (burst_o),
        .ready_o    (ready_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int CYC_PER_MS = 200000
) (
    input logic clk_i,
    input logic rst_ni,
    input logic wmask_o,
    input logic stage1_o,
    input logic stage2_o,
    input logic iso_o,
    input logic burst_o,
    input logic ready_o,
    input logic busy_o,
    input logic done_o
);
    int up_cnt;
    int dn_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            up_cnt <= 0;
            dn_cnt <= 0;
        end else begin
            if (!stage1_o || stage2_o) up_cnt <= 0;
            else if (up_cnt < CYC_PER_MS + 2) up_cnt <= up_cnt + 1;
            if (stage2_o || !stage1_o) dn_cnt <= 0;
            else if (dn_cnt < CYC_PER_MS + 2) dn_cnt <= dn_cnt + 1;
        end
    end

    assert_s1_needs_wmask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stage1_o |-> wmask_o);

    assert_up_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stage2_o) |-> (up_cnt == CYC_PER_MS));

    assert_dn_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(stage1_o) |-> (dn_cnt == CYC_PER_MS));

    assert_iso_needs_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !iso_o |-> stage2_o);

    assert_s2_needs_s1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stage2_o |-> stage1_o);

    assert_burst_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        burst_o |-> !iso_o);

    assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !$past(busy_o)) |-> $stable({wmask_o, stage1_o, stage2_o, iso_o, burst_o}));

    assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_ready_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o != $past(ready_o)) |-> done_o);

    assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

endmodule

bind fuse_pwr_seq fps_checker #(
    .CYC_PER_MS(CYC_PER_MS)
) i_fps_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wmask_o  (wmask_o),
    .stage1_o (stage1_o),
    .stage2_o (stage2_o),
    .iso_o    (iso_o),
    .burst_o  (burst_o),
    .ready_o  (ready_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/test_fuse_pwr_seq.sv
`timescale 1ns/1ps
module test_fuse_pwr_seq;
    localparam int N = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass = 1'b0;
    logic variant = 1'b0;
    logic up_req = 1'b0;
    logic down_req = 1'b0;
    logic wmask, s1, s2, iso, burst, ready, busy, done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fuse_pwr_seq #(.CYC_PER_MS(N)) i_fuse_pwr_seq (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bypass_i   (bypass),
        .variant_i  (variant),
        .up_req_i   (up_req),
        .down_req_i (down_req),
        .wmask_o    (wmask),
        .stage1_o   (s1),
        .stage2_o   (s2),
        .iso_o      (iso),
        .burst_o    (burst),
        .ready_o    (ready),
        .busy_o     (busy),
        .done_o     (done)
    );

    // bit order: wmask s1 s2 iso burst ready done busy
    function automatic string tag_of(logic [7:0] diff, bit down);
        if (diff[7] || diff[6]) return down ? "R5" : "R2";
        if (diff[5])            return down ? "R5" : "R3";
        if (diff[4])            return down ? "R5" : "R4";
        if (diff[3])            return "R6";
        if (diff[2] || diff[1]) return "R9";
        return "R8";
    endfunction

    task automatic check_outs(input logic [7:0] exp, input bit down, input string ctx);
        logic [7:0] act;
        act = {wmask, s1, s2, iso, burst, ready, done, busy};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag_of(act ^ exp, down), ctx, act, exp);
        end
        checks++;
        if ((s2 && !s1) || (s1 && !wmask) || (!iso && !s2)) begin
            failures++;
            $display("FAIL R10 %s nesting actual=%b expected=nested", ctx, act);
        end
    endtask

    function automatic logic [7:0] exp_up(int t, bit v);
        int last;
        last = N + 2 + int'(v);
        return {1'b1, t >= 1, t >= N + 1, !(t >= N + 2), v && (t >= N + 3),
                t >= last, t == last, t < last};
    endfunction

    function automatic logic [7:0] exp_down(int t, bit v);
        int b, last;
        b = int'(v);
        last = b + 2 + N;
        return {!(t >= last), !(t >= b + 1 + N), !(t >= b + 1), t >= b, 1'b0,
                !(t >= last), t == last, t < last};
    endfunction

    task automatic run_seq(input bit up, input bit v, input bit noise);
        int last;
        last = up ? (N + 2 + int'(v)) : (N + 2 + int'(v));
        variant = v;
        @(negedge clk);
        if (up) up_req = 1'b1; else down_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        down_req = 1'b0;
        for (int t = 0; t <= last + 2; t++) begin
            if (up) check_outs(exp_up(t, v), 1'b0, $sformatf("up v=%0d n=%0d t=%0d", v, noise, t));
            else    check_outs(exp_down(t, v), 1'b1, $sformatf("down v=%0d n=%0d t=%0d", v, noise, t));
            if (noise && t == 2) begin
                up_req = 1'b1;
                down_req = 1'b1;
                variant = !v;
            end else begin
                up_req = 1'b0;
                down_req = 1'b0;
            end
            @(negedge clk);
        end
        variant = v;
    endtask

    task automatic idle_ignore(input bit up, input bit v);
        @(negedge clk);
        if (up) up_req = 1'b1; else down_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        down_req = 1'b0;
        for (int t = 0; t < 3; t++) begin
            // R8: redundant request ignored
            if (up) check_outs(exp_up(N + 10, v), 1'b0, $sformatf("R8 redundant up t=%0d", t));
            else    check_outs(exp_down(N + 10, v), 1'b1, $sformatf("R8 redundant down t=%0d", t));
            @(negedge clk);
        end
    endtask

    task automatic bypass_pair(input bit v);
        bypass = 1'b1;
        variant = v;
        @(negedge clk);
        up_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        check_outs(8'b0001_0110, 1'b0, "R7 bypass up t=0");
        @(negedge clk);
        check_outs(8'b0001_0100, 1'b0, "R7 bypass up t=1");
        down_req = 1'b1;
        @(negedge clk);
        down_req = 1'b0;
        check_outs(8'b0001_0010, 1'b1, "R7 bypass down t=0");
        @(negedge clk);
        check_outs(8'b0001_0000, 1'b1, "R7 bypass down t=1");
        bypass = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_outs(8'b0001_0000, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_outs(8'b0001_0000, 1'b0, "R1 after reset");
        idle_ignore(1'b0, 1'b0);
        for (int v = 0; v < 2; v++) begin
            for (int n = 0; n < 2; n++) begin
                run_seq(1'b1, v[0], n[0]);
                idle_ignore(1'b1, v[0]);
                run_seq(1'b0, v[0], n[0]);
                idle_ignore(1'b0, v[0]);
            end
            bypass_pair(v[0]);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule